// File: doc/BRIEF.md
# Decimal Digit Counter with Seven-Segment Drive

This block counts clock edges from 0 to 9 and wraps back to 0. The count is never presented in binary. It is decoded straight onto seven active-high segment lines that light a common-cathode digit. A clock-hold input freezes the count. A display-enable input blanks the digit without stopping the count. Two outputs support chaining: a registered copy of the display-enable input, and a carry line that gives one rising edge for every wrap of the decade.

To build a multi-digit counter, the carry of one instance is used as the count source of the next digit. Blanking is applied by the display-enable input and does not depend on the clock. The count underneath keeps running, so a digit that is blanked and then re-enabled shows the value that was reached in the meantime.

Top module: `decade_seg_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, the count becomes 0 and `en_out` becomes 0 after that edge.
- R2: When `rst_n` is high and `hold` is low, the count rises by one at each rising edge of `clk`.
- R3: From a count of 9, the next counting edge returns the count to 0.
- R4: While `hold` is high at a rising edge (with `rst_n` high), the count is unchanged.
- R5: Segment bit 0 is a (top), and bits 1 to 5 go clockwise as b, c, d, e, f. Bit 6 is g (middle). With `disp_en` high, `seg` shows these digit patterns: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R6: While `disp_en` is low, `seg` is 0x00 in the same cycle, with no clock edge needed.
- R7: Counting continues while the digit is blanked. When `disp_en` returns high, the digit shows the count that was reached.
- R8: `en_out` equals the value `disp_en` had at the previous rising edge of `clk`.
- R9: `carry` is high for counts 0 to 4 and low for counts 5 to 9. As a result it rises exactly when the count wraps from 9 to 0.
- R10: Reset takes priority over `hold`. A low `rst_n` clears the count even while `hold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; the count advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | High freezes the count |
| disp_en | input | 1 | High shows the digit; low blanks all segments |
| seg | output | 7 | Segment lines, bit 0 = a through bit 6 = g, active high |
| en_out | output | 1 | Display-enable delayed by one clock |
| carry | output | 1 | High for counts 0 to 4; rises once per decade |

## Verification
A wrong count shows up on `seg` at the very next sampling point whenever the digit is enabled. A count that is off by one, or a wrap that comes early or late, gives a pattern that differs from the expected glyph. The same fault usually also moves the `carry` boundary between 4 and 5. A count that drifts while the digit is blanked stays hidden until `disp_en` returns high, and then appears on the first enabled cycle. A stale or missing stage in the enable path appears on `en_out` one cycle after any change of `disp_en`.

// File: rtl/decade_seg_pkg.sv
// Package: shared widths and segment lighting masks for the decimal digit counter.
// Assumes the modulus never exceeds ten, since only glyphs 0..9 are defined.
package decade_seg_pkg;

    localparam int SEG_W     = 7;
    localparam int GLYPH_CNT = 10;

    typedef logic [SEG_W-1:0] seg_t;

    // Segment indices: a on top, clockwise to f, g in the middle.
    typedef enum int {
        SEG_A = 0, SEG_B = 1, SEG_C = 2, SEG_D = 3,
        SEG_E = 4, SEG_F = 5, SEG_G = 6
    } seg_idx_e;

    // For each segment, bit n is set when digit n lights that segment.
    localparam logic [GLYPH_CNT-1:0] SEG_LIT [SEG_W] = '{
        10'b1111101101,  // a
        10'b1110011111,  // b
        10'b1111111011,  // c
        10'b1101101101,  // d
        10'b0101000101,  // e
        10'b1101110001,  // f
        10'b1101111100   // g
    };

endpackage

// File: rtl/decade_count_core.sv
// Module: modulo-N up counter with hold and synchronous active-low reset.
// Assumes MODULUS >= 2. Reset overrides hold; hold freezes the count.
module decade_count_core #(
    parameter int MODULUS = 10,
    localparam int CNT_W  = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    // Next count: wrap at the last value, otherwise step by one.
    always_comb begin
        if (cnt_q == LAST) begin
            cnt_next = '0;
        end else begin
            cnt_next = cnt_q + 1'b1;
        end
    end

    // Count register: reset first, then hold, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!hold_i) begin
            cnt_q <= cnt_next;
        end
    end

    assign cnt_o = cnt_q;

    // R1 R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && cnt_q == LAST) |=> (cnt_q == '0));

    // R4
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(cnt_q));

    // R3
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/seg_glyph_decoder.sv
// Module: turns a digit value into active-high segment lines, with blanking.
// Assumes the value is below ten; blanking acts combinationally.
module seg_glyph_decoder
    import decade_seg_pkg::*;
#(
    parameter int VAL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] val_i,
    input  logic             show_i,
    output seg_t             seg_o
);

    seg_t lit;

    // One lookup per segment: is this segment part of the current glyph.
    for (genvar s = 0; s < SEG_W; s++) begin : g_seg
        assign lit[s] = SEG_LIT[s][val_i];
    end

    // Blank gate: all segments dark while the display is disabled.
    always_comb begin
        seg_o = show_i ? lit : '0;
    end

    // R6
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !show_i |-> (seg_o == '0));

    // R5
    shown_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        show_i |-> (seg_o != '0));

endmodule

// File: rtl/enable_delay_line.sv
// Module: registered delay of the display-enable for passing down a chain.
// Assumes STAGES >= 1; each stage adds one clock of latency.
module enable_delay_line #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic en_o
);

    logic [STAGES-1:0] pipe_q;

    // First stage samples the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q[0] <= 1'b0;
        end else begin
            pipe_q[0] <= en_i;
        end
    end

    // Further stages shift the value onward.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q[i] <= 1'b0;
            end else begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign en_o = pipe_q[STAGES-1];

    if (STAGES == 1) begin : g_one_chk
        // R8
        en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (en_o == $past(en_i)));
    end

    // R1
    en_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !en_o);

endmodule

// File: rtl/decade_seg_counter.sv
// Module: top of the decimal digit counter with segment drive and chain outputs.
// Assumes MODULUS <= 10. Carry is high for the lower half of the range.
module decade_seg_counter
    import decade_seg_pkg::*;
#(
    parameter int MODULUS   = 10,
    parameter int EN_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             disp_en,
    output logic [SEG_W-1:0] seg,
    output logic             en_out,
    output logic             carry
);

    localparam int CNT_W = $clog2(MODULUS);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(MODULUS / 2);

    logic [CNT_W-1:0] cnt;

    decade_count_core #(.MODULUS(MODULUS)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold),
        .cnt_o  (cnt)
    );

    seg_glyph_decoder #(.VAL_W(CNT_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .val_i  (cnt),
        .show_i (disp_en),
        .seg_o  (seg)
    );

    enable_delay_line #(.STAGES(EN_STAGES)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (disp_en),
        .en_o  (en_out)
    );

    // Carry: lower half of the range drives high, so the wrap gives a rising edge.
    always_comb begin
        carry = (cnt < HALF);
    end

    // R9
    carry_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry) |-> (cnt == '0));

    // R9
    carry_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carry) |-> ($past(cnt) == HALF - 1'b1));

endmodule

// File: tb/decade_seg_counter_tb.sv
`timescale 1ns/1ps
module decade_seg_counter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold = 1'b0;
    logic       disp_en = 1'b1;
    logic [6:0] seg;
    logic       en_out;
    logic       carry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int  exp_cnt = 0;
    bit  exp_en = 1'b0;
    bit  model_ok = 1'b0;
    string last_tag = "R1";

    always #4 clk = ~clk;

    decade_seg_counter u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .disp_en (disp_en),
        .seg     (seg),
        .en_out  (en_out),
        .carry   (carry)
    );

    // Expected glyph, bit 0 = a ... bit 6 = g (R5).
    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'h3F;
            1: return 7'h06;
            2: return 7'h5B;
            3: return 7'h4F;
            4: return 7'h66;
            5: return 7'h6D;
            6: return 7'h7D;
            7: return 7'h07;
            8: return 7'h7F;
            9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check_all();
        logic [6:0] es;
        string st;
        if (!model_ok) return;
        es = disp_en ? glyph(exp_cnt) : 7'h00;
        st = disp_en ? last_tag : "R6";
        checks++;
        if (seg !== es) begin
            errors++;
            $display("FAIL %s seg actual=%h expected=%h", st, seg, es);
        end
        checks++;
        if (en_out !== exp_en) begin
            errors++;
            $display("FAIL R8 en_out actual=%b expected=%b", en_out, exp_en);
        end
        checks++;
        if (carry !== (exp_cnt < 5)) begin
            errors++;
            $display("FAIL R9 carry actual=%b expected=%b", carry, (exp_cnt < 5));
        end
    endtask

    // Check the previous result, drive new inputs, then advance the model.
    task automatic step(input logic r, input logic h, input logic d, input string tag);
        @(negedge clk);
        check_all();
        rst_n = r;
        hold = h;
        disp_en = d;
        last_tag = tag;
        @(posedge clk);
        if (!r) begin
            exp_cnt = 0;
            exp_en = 1'b0;
            model_ok = 1'b1;
        end else begin
            if (!h) exp_cnt = (exp_cnt == 9) ? 0 : exp_cnt + 1;
            exp_en = d;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        step(1'b0, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, 1'b1, "R1");
        // R2: count up through every digit
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b1, "R2");
        // R3: wrap from 9 back to 0 and beyond
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R3");
        // R4: hold freezes the count
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, "R4");
        // R6: blanked while counting, R8 sees the enable toggle
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, "R6");
        // R7: re-enabled digit shows the count reached while dark
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R7");
        // R10: reset wins over hold
        step(1'b1, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b1, 1'b1, "R10");
        step(1'b1, 1'b1, 1'b1, "R10");
        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 40) != 0, ($urandom % 4) == 0,
                 ($urandom % 5) != 0, "R2");
        end
        @(negedge clk);
        check_all();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule